// File: doc/BRIEF.md
# Counted Block Memory Copier

This block moves a run of bytes from one place in a byte-wide memory to another. A caller presents a source pointer, a destination pointer, a transfer count and a width selector, then pulses `start`. The block fetches one byte at the source pointer and stores that byte at the destination pointer. It then advances both pointers by one and lowers the count by one. It repeats this until the count is exhausted. In narrow-count mode only the low 8 bits of the count input are used, which gives at most 255 bytes. In wide-count mode all 16 bits are used, which gives at most 65535 bytes. A count of zero finishes at once and makes no memory access.

The sequencer has five states. IDLE waits for `start`. READ holds a read request at the source pointer until the memory accepts it. WAIT_READ waits for the returned byte. WRITE holds a write request at the destination pointer until it is accepted. DONE is a one-cycle completion state. The transitions are:
- IDLE to READ on `start` with a nonzero count.
- IDLE to DONE on `start` with a zero count.
- READ to WAIT_READ on `mem_ready`.
- WAIT_READ to WRITE on `mem_rvalid`.
- WRITE to READ on `mem_ready` while bytes remain.
- WRITE to DONE on `mem_ready` for the last byte.
- DONE to IDLE unconditionally.

After completion, the final pointers and the zero count stay on the outputs until the next accepted start.

Top module: `blk_copier`

## Requirements
- R1: While reset is asserted and after it is released, the block is in IDLE: `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: With `word_mode` = 0 the transfer count is `cnt_in[7:0]` and `cnt_in[15:8]` has no effect. With `word_mode` = 1 the count is all 16 bits of `cnt_in`.
- R3: A start whose effective count is zero raises `done` in the very next cycle. It issues no read and no write.
- R4: Every copied byte is read at the current source pointer, and the byte returned on `mem_rdata` is written unchanged at the current destination pointer. A start with count N performs exactly N reads and N writes.
- R5: Each accepted write advances the source and destination pointers by one and lowers the count by one. Pointers wrap modulo 2^32.
- R6: `mem_rd` and `mem_wr` are never high together. A new read is requested only after the previous byte's write has been accepted, so at most one read is outstanding.
- R7: A request that is not accepted (`mem_ready` low) is held on the next cycle with the same address and, for a write, the same data.
- R8: `done` is high for exactly one cycle. That cycle directly follows the acceptance of the final write, and the block is idle afterwards.
- R9: After completion `src_out` and `dst_out` equal the start pointers plus the count, and `cnt_out` is zero. These values are held until the next accepted start.
- R10: A `start` pulse while `busy` is high (including the DONE cycle) is ignored. It changes neither the pointers, the count, nor the memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy; honoured only in IDLE |
| word_mode | input | 1 | 0: 8-bit count, 1: 16-bit count |
| src_in | input | 32 | Initial source pointer |
| dst_in | input | 32 | Initial destination pointer |
| cnt_in | input | 16 | Transfer count in bytes |
| busy | output | 1 | High in every state except IDLE |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 32 | Current or final source pointer |
| dst_out | output | 32 | Current or final destination pointer |
| cnt_out | output | 16 | Bytes still to copy |
| mem_addr | output | 32 | Memory address: source in READ, destination in WRITE |
| mem_rd | output | 1 | Read request, held until accepted |
| mem_wr | output | 1 | Write request, held until accepted |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Returned read byte |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| mem_ready | input | 1 | Memory accepts the current request |

## Verification
The delicate overlap is the acceptance of the final write landing in the same cycle as a fresh `start` request. The block must finish the current copy and discard the new request rather than chaining into a second transfer. The bench provokes this by raising `start` exactly when it sees a write with one byte remaining and `mem_ready` high. It then judges the result in three ways:
- `done` must appear in the following cycle.
- The final pointers must match the original transfer.
- No further read may be issued while the block sits idle afterwards.

Memory stalls and variable read latency are applied alongside, so held requests are exercised in the same runs.

// File: rtl/blkcp_pkg.sv
package blkcp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ      = 3'd1,
        ST_WAIT_READ = 3'd2,
        ST_WRITE     = 3'd3,
        ST_DONE      = 3'd4
    } cp_state_t;

endpackage

// File: rtl/blkcp_fsm.sv
module blkcp_fsm
    import blkcp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      eff_zero,
    input  logic      last_byte,
    input  logic      mem_ready,
    input  logic      mem_rvalid,
    output cp_state_t state,
    output logic      load,
    output logic      step,
    output logic      capture
);

    cp_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt = eff_zero ? ST_DONE : ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready) begin
                    nxt = ST_WAIT_READ;
                end
            end
            ST_WAIT_READ: begin
                if (mem_rvalid) begin
                    nxt = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    nxt = last_byte ? ST_DONE : ST_READ;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath controls
    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE:      load    = start;
            ST_READ:      ;
            ST_WAIT_READ: capture = mem_rvalid;
            ST_WRITE:     step    = mem_ready;
            ST_DONE:      ;
            default:      ;
        endcase
    end

endmodule

// File: rtl/blkcp_regs.sv
module blkcp_regs #(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int BCW = 8,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_mode,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          load,
    input  logic          step,
    input  logic          capture,
    input  logic [DW-1:0] mem_rdata,
    output logic          eff_zero,
    output logic          last_byte,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic [DW-1:0] data_q
);

    localparam int PAD = CW - BCW;

    logic [CW-1:0] narrow_cnt;
    logic [CW-1:0] eff_cnt;

    generate
        if (PAD > 0) begin : g_pad
            assign narrow_cnt = {{PAD{1'b0}}, cnt_in[BCW-1:0]};
        end else begin : g_nopad
            assign narrow_cnt = cnt_in;
        end
    endgenerate

    assign eff_cnt   = word_mode ? cnt_in : narrow_cnt;
    assign eff_zero  = (eff_cnt == '0);
    assign last_byte = (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            src_q <= src_in;
            dst_q <= dst_in;
            cnt_q <= eff_cnt;
        end else if (step) begin
            src_q <= src_q + AW'(1);
            dst_q <= dst_q + AW'(1);
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/blk_copier.sv
module blk_copier
    import blkcp_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int BCW = 8,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          word_mode,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    input  logic          mem_ready
);

    cp_state_t     state;
    logic          load;
    logic          step;
    logic          capture;
    logic          eff_zero;
    logic          last_byte;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] data_q;

    blkcp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .eff_zero   (eff_zero),
        .last_byte  (last_byte),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .state      (state),
        .load       (load),
        .step       (step),
        .capture    (capture)
    );

    blkcp_regs #(.AW(AW), .CW(CW), .BCW(BCW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_mode (word_mode),
        .src_in    (src_in),
        .dst_in    (dst_in),
        .cnt_in    (cnt_in),
        .load      (load),
        .step      (step),
        .capture   (capture),
        .mem_rdata (mem_rdata),
        .eff_zero  (eff_zero),
        .last_byte (last_byte),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .data_q    (data_q)
    );

    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        unique case (state)
            ST_IDLE:      busy   = 1'b0;
            ST_READ:      mem_rd = 1'b1;
            ST_WAIT_READ: ;
            ST_WRITE:     mem_wr = 1'b1;
            ST_DONE:      done   = 1'b1;
            default:      busy   = 1'b0;
        endcase
    end

    assign mem_addr  = mem_wr ? dst_q : src_q;
    assign mem_wdata = data_q;
    assign src_out   = src_q;
    assign dst_out   = dst_q;
    assign cnt_out   = cnt_q;

endmodule

// File: rtl/blkcp_chk.sv
module blkcp_chk #(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int BCW = 8,
    parameter int DW  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          word_mode,
    input logic [CW-1:0] cnt_in,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] src_out,
    input logic [AW-1:0] dst_out,
    input logic [CW-1:0] cnt_out,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready
);

    logic zero_req;
    assign zero_req = word_mode ? (cnt_in == '0) : (cnt_in[BCW-1:0] == '0);

    assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ready) |=> (cnt_out == $past(cnt_out) - CW'(1)
                                   && src_out == $past(src_out) + AW'(1)
                                   && dst_out == $past(dst_out) + AW'(1)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_zero_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && zero_req) |=> (done && !mem_rd && !mem_wr));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !(mem_wr && mem_ready)) |=> ($stable(cnt_out) && $stable(src_out)
                                                     && $stable(dst_out)));

endmodule

bind blk_copier blkcp_chk #(.AW(AW), .CW(CW), .BCW(BCW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .word_mode (word_mode),
    .cnt_in    (cnt_in),
    .busy      (busy),
    .done      (done),
    .src_out   (src_out),
    .dst_out   (dst_out),
    .cnt_out   (cnt_out),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/blk_copier_tb_top.sv
`timescale 1ns/1ps
module blk_copier_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_mode = 1'b0;
    logic [31:0] src_in = '0;
    logic [31:0] dst_in = '0;
    logic [15:0] cnt_in = '0;
    logic        busy, done;
    logic [31:0] src_out, dst_out, mem_addr;
    logic [15:0] cnt_out;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;

    blk_copier dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
        .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
        .cnt_out(cnt_out), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .mem_ready(mem_ready)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [7:0]  d;
    } wr_item_t;

    wr_item_t    exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          reads = 0;
    int          writes = 0;
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        rd_take = 1'b0;
    logic [31:0] take_addr = '0;
    logic [31:0] raddr = '0;
    logic [1:0]  lat = '0;
    logic        rd_open = 1'b0;
    logic        prev_rd_stall = 1'b0;
    logic        prev_wr_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [7:0]  prev_data = '0;
    logic        expect_done = 1'b0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ {a[3:0], 4'h3};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: ready pattern and read return, driven with nonblocking updates
    always @(posedge clk) begin
        lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready  <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
        mem_rvalid <= 1'b0;
        if (rd_take) begin
            lat   <= lfsr[5] ? 2'd2 : 2'd1;
            raddr <= take_addr;
        end else if (lat != 2'd0) begin
            lat <= lat - 2'd1;
            if (lat == 2'd1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= pat(raddr);
            end
        end
    end

    // monitor: values at the falling edge are those seen by the next rising edge
    always @(negedge clk) begin
        wr_item_t it;
        rd_take   = rst_n && mem_rd && mem_ready;
        take_addr = mem_addr;
        if (rst_n) begin
            if (mem_rd && mem_wr) chk(1'b0, "R6 read and write together", 32'd1, 32'd0);
            if (prev_rd_stall) chk(mem_rd && mem_addr == prev_addr, "R7 stalled read held", mem_addr, prev_addr);
            if (prev_wr_stall) chk(mem_wr && mem_addr == prev_addr && mem_wdata == prev_data,
                                   "R7 stalled write held", {24'd0, mem_wdata}, {24'd0, prev_data});
            if (expect_done) begin
                chk(done, "R8 done right after last write", {31'd0, done}, 32'd1);
                expect_done = 1'b0;
            end
            if (rd_take) begin
                reads++;
                if (rd_open) chk(1'b0, "R6 read before previous write accepted", mem_addr, 32'd0);
                rd_open = 1'b1;
            end
            if (mem_wr && mem_ready) begin
                writes++;
                rd_open = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", mem_addr, 32'd0);
                end else begin
                    it = exp_q.pop_front();
                    chk(mem_addr == it.a, "R5 write address", mem_addr, it.a);
                    chk(mem_wdata == it.d, "R4 write data", {24'd0, mem_wdata}, {24'd0, it.d});
                end
                if (cnt_out == 16'd1) expect_done = 1'b1;
            end
            prev_rd_stall = mem_rd && !mem_ready;
            prev_wr_stall = mem_wr && !mem_ready;
            prev_addr     = mem_addr;
            prev_data     = mem_wdata;
        end
    end

    // driver: mode 0 plain, 1 start pulse mid-transfer, 2 start on final write acceptance
    task automatic run(input bit wm, input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] c, input bit stl, input int mode, input string tag);
        int n;
        int r0;
        int w0;
        int guard;
        n = wm ? int'(c) : int'(c[7:0]);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{a: d + 32'(i), d: pat(s + 32'(i))});
        end
        stall_en = stl;
        r0 = reads;
        w0 = writes;
        @(negedge clk);
        start = 1'b1; word_mode = wm; src_in = s; dst_in = d; cnt_in = c;
        @(negedge clk);
        start = 1'b0; src_in = ~s; dst_in = ~d; cnt_in = ~c;
        if (n == 0) begin
            chk(done, {tag, " R3 done one cycle after start"}, {31'd0, done}, 32'd1);
        end else begin
            if (mode == 1) begin
                guard = 0;
                while (writes < w0 + 2 && guard < 5000) begin @(negedge clk); guard++; end
                start = 1'b1; word_mode = 1'b1; src_in = 32'h5000_0000; cnt_in = 16'h0040;
                @(negedge clk);
                start = 1'b0;
            end else if (mode == 2) begin
                guard = 0;
                while (!(mem_wr && mem_ready && cnt_out == 16'd1) && guard < 5000) begin
                    @(negedge clk); guard++;
                end
                start = 1'b1; word_mode = 1'b1; src_in = 32'h6000_0000; cnt_in = 16'h0020;
                @(negedge clk);
                start = 1'b0;
                chk(done, {tag, " R10 done despite start at final write"}, {31'd0, done}, 32'd1);
            end
            guard = 0;
            while (!done && guard < 20000) begin @(negedge clk); guard++; end
        end
        chk(done, {tag, " R8 done seen"}, {31'd0, done}, 32'd1);
        chk(src_out == s + 32'(n), {tag, " R9 final source"}, src_out, s + 32'(n));
        chk(dst_out == d + 32'(n), {tag, " R9 final destination"}, dst_out, d + 32'(n));
        chk(cnt_out == 16'd0, {tag, " R9 final count"}, {16'd0, cnt_out}, 32'd0);
        chk(reads == r0 + n, {tag, " R4 read count"}, reads - r0, n);
        chk(writes == w0 + n, {tag, " R4 write count"}, writes - w0, n);
        repeat (4) @(negedge clk);
        chk(!busy && !done, {tag, " R10 idle after completion"}, {30'd0, busy, done}, 32'd0);
        chk(src_out == s + 32'(n) && dst_out == d + 32'(n) && cnt_out == 16'd0,
            {tag, " R9 results held"}, src_out, s + 32'(n));
        chk(reads == r0 + n, {tag, " R10 no extra reads"}, reads - r0, n);
        chk(exp_q.size() == 0, {tag, " R4 all bytes written"}, exp_q.size(), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1 reset state",
            {28'd0, busy, done, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1 idle after reset",
            {28'd0, busy, done, mem_rd, mem_wr}, 32'd0);

        run(1'b0, 32'h0000_1000, 32'h0000_2000, 16'h0005, 1'b0, 0, "byte5");
        run(1'b0, 32'h0000_3010, 32'h0000_4020, 16'h0107, 1'b1, 0, "R2 byte-upper-ignored");
        run(1'b0, 32'h0000_5000, 32'h0000_6000, 16'h0100, 1'b1, 0, "R2 byte-zero");
        run(1'b1, 32'h0000_7000, 32'h0000_8000, 16'h0000, 1'b0, 0, "R3 word-zero");
        run(1'b1, 32'h1234_0000, 32'h2345_0080, 16'd300, 1'b1, 0, "R2 word300");
        run(1'b1, 32'hFFFF_FFFD, 32'hFFFF_FFFE, 16'h0006, 1'b1, 0, "R5 wrap");
        run(1'b0, 32'h0000_9000, 32'h0000_A000, 16'h0008, 1'b1, 1, "R10 intrude");
        run(1'b0, 32'h0000_B000, 32'h0000_C000, 16'h0004, 1'b1, 2, "R10 collide");
        run(1'b0, 32'h0001_0000, 32'h0002_0000, 16'h00FF, 1'b1, 0, "R2 byte255");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule